// File: doc/BRIEF.md
# Lazily Invalidating Direct-Mapped Load Cache

This block is a small direct-mapped read cache for one processor in a multiprocessor with a relaxed memory ordering. Coherence invalidations from other agents are accepted and acknowledged at once. They are not applied at once. Each one is parked in a short FIFO of line addresses. Entries leave the FIFO only in cycles when neither a processor load nor a line fill needs the tag array. They also leave when the processor raises a memory barrier, which holds until the FIFO has emptied.

Because of this deferral, a load may hit a line whose invalidation has already been acknowledged and still return the old contents. This is legal under the ordering model; a barrier is the processor's way to observe remote writes. A load that misses sends one request toward memory, does not drain the FIFO first, and installs the returned line. Queued invalidations for that same line are neutralised when the line is installed, so they cannot later evict the fresh copy.

Top module: `lazy_inval_cache`

## Requirements
- R1: After reset every line is invalid, the FIFO is empty, and `inv_ack`, `mem_req`, `rsp_valid` and `bar_done` are low; the first load to any address therefore misses.
- R2: An invalidation is accepted in a cycle where `inv_valid` and `inv_ready` are both high, and `inv_ack` is high in exactly the next cycle, whether or not the entry has been applied yet.
- R3: The FIFO holds at most `Q_DEPTH` (8) entries. While it is full, `inv_ready` and `ld_ready` are both low, so the cycle is free for draining and one slot frees.
- R4: One FIFO entry is retired only in a cycle where no load is accepted and no fill is taken.
- R5: Retiring an entry clears a line's valid bit only if that line holds the queued address (index is the low `IDX_W` address bits, tag the rest); otherwise the entry has no effect.
- R6: While `bar_req` is high, loads are refused. `bar_done` is high exactly when `bar_req` is high, the FIFO is empty and no miss is outstanding.
- R7: A load accepted on a miss raises `mem_req` with the line address on `mem_addr` from the next cycle until the cycle where `mem_fill_valid` is high. The cycle after the fill, `rsp_valid` is high with the fill data and the line is installed.
- R8: A load accepted on a hit gives `rsp_valid` with the stored data in the next cycle, even when an invalidation for that line is queued.
- R9: A fill marks every queued entry with the filled address as void. A void entry is retired later without touching the line.
- R10: At most one miss is outstanding: `ld_ready` is low from the cycle after a miss is accepted until the fill is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Processor load request |
| ld_addr | input | ADDR_W | Line address of the load |
| ld_ready | output | 1 | Load is accepted this cycle if valid |
| rsp_valid | output | 1 | Load data is available |
| rsp_data | output | DATA_W | Load data |
| bar_req | input | 1 | Memory barrier request, held until done |
| bar_done | output | 1 | Barrier may complete |
| inv_valid | input | 1 | Incoming invalidation |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_ready | output | 1 | Invalidation can be accepted |
| inv_ack | output | 1 | Acknowledge for the invalidation accepted last cycle |
| mem_req | output | 1 | Miss request toward memory |
| mem_addr | output | ADDR_W | Line address of the miss |
| mem_fill_valid | input | 1 | Fill data is returned |
| mem_fill_data | input | DATA_W | Returned line data |

## Verification
The hardest condition to reach from the ports is a fill that arrives while an invalidation for the very same line is still queued, since any idle array cycle drains the FIFO. The stimulus first installs one line and hits on it in every cycle, which starves the drain, while it pushes a run of invalidations ending with the address it is about to miss on. A miss to that address with a memory latency shorter than the backlog then lands the fill on a still-queued entry, and a later barrier followed by a load shows the line survived. The stale hit is reached the same way: a load in the cycle after the invalidation keeps the array busy, so the entry is still pending.

// File: rtl/lic_pkg.sv
package lic_pkg;

   typedef enum logic {
      LIC_IDLE = 1'b0,
      LIC_MISS = 1'b1
   } lic_state_e;

   function automatic int lic_cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/lic_inval_queue.sv
module lic_inval_queue #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 8,
   localparam int CNT_W = lic_pkg::lic_cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   input  logic              void_en,
   input  logic [ADDR_W-1:0] void_addr,
   output logic [ADDR_W-1:0] head_addr,
   output logic              head_void,
   output logic [CNT_W-1:0]  count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("lic_inval_queue: DEPTH must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lic_inval_queue: ADDR_W must be at least 2");
   end

   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] slot_addr [DEPTH];
   logic              slot_void [DEPTH];

   function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= adv(wr_ptr);
         if (pop)  rd_ptr <= adv(rd_ptr);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ADDR_W-1:0] a_q;
      logic              v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            v_q <= 1'b0;
         end else if (push && wr_ptr == PTR_W'(i)) begin
            a_q <= push_addr;
            v_q <= 1'b0;
         end else if (void_en && a_q == void_addr) begin
            v_q <= 1'b1;
         end
      end
      assign slot_addr[i] = a_q;
      assign slot_void[i] = v_q;
   end

   assign head_addr = slot_addr[rd_ptr];
   assign head_void = slot_void[rd_ptr];
   assign count     = cnt_q;

endmodule

// File: rtl/lic_line_store.sv
module lic_line_store #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   localparam int LINES = 1 << IDX_W,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr
);

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("lic_line_store: IDX_W must be between 1 and ADDR_W-1");
   end

   logic              line_vld [LINES];
   logic [TAG_W-1:0]  line_tag [LINES];
   logic [DATA_W-1:0] line_dat [LINES];

   logic [IDX_W-1:0] lk_idx, wr_idx, clr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag, clr_tag;

   assign lk_idx  = lk_addr[IDX_W-1:0];
   assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
   assign wr_idx  = wr_addr[IDX_W-1:0];
   assign wr_tag  = wr_addr[ADDR_W-1:IDX_W];
   assign clr_idx = clr_addr[IDX_W-1:0];
   assign clr_tag = clr_addr[ADDR_W-1:IDX_W];

   for (genvar j = 0; j < LINES; j++) begin : g_line
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(j)) begin
            v_q <= 1'b1;
            t_q <= wr_tag;
            d_q <= wr_data;
         end else if (clr_en && clr_idx == IDX_W'(j) && t_q == clr_tag) begin
            v_q <= 1'b0;
         end
      end
      assign line_vld[j] = v_q;
      assign line_tag[j] = t_q;
      assign line_dat[j] = d_q;
   end

   assign lk_hit  = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);
   assign lk_data = line_dat[lk_idx];

endmodule

// File: rtl/lic_access_ctrl.sv
module lic_access_ctrl #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int CNT_W = lic_pkg::lic_cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              bar_req,
   output logic              bar_done,
   input  logic              inv_valid,
   output logic              inv_ready,
   output logic              inv_ack,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_fill_valid,
   input  logic [DATA_W-1:0] mem_fill_data,
   input  logic              lk_hit,
   input  logic [DATA_W-1:0] lk_data,
   input  logic [CNT_W-1:0]  q_count,
   input  logic              q_head_void,
   output logic              q_push,
   output logic              q_pop,
   output logic              apply_en,
   output logic              fill_en
);

   import lic_pkg::*;

   lic_state_e        st_q;
   logic [ADDR_W-1:0] miss_addr_q;
   logic              rsp_v_q, ack_q;
   logic [DATA_W-1:0] rsp_d_q;
   logic              q_full, q_empty, ld_acc;

   assign q_full  = (q_count == CNT_W'(DEPTH));
   assign q_empty = (q_count == '0);

   assign ld_ready  = (st_q == LIC_IDLE) && !q_full && !bar_req;
   assign ld_acc    = ld_valid && ld_ready;
   assign fill_en   = (st_q == LIC_MISS) && mem_fill_valid;
   assign inv_ready = !q_full;
   assign q_push    = inv_valid && inv_ready;
   assign q_pop     = !q_empty && !ld_acc && !fill_en;
   assign apply_en  = q_pop && !q_head_void;
   assign bar_done  = bar_req && q_empty && (st_q == LIC_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= LIC_IDLE;
         miss_addr_q <= '0;
         rsp_v_q     <= 1'b0;
         rsp_d_q     <= '0;
         ack_q       <= 1'b0;
      end else begin
         ack_q   <= q_push;
         rsp_v_q <= fill_en || (ld_acc && lk_hit);
         if (fill_en) begin
            rsp_d_q <= mem_fill_data;
            st_q    <= LIC_IDLE;
         end else if (ld_acc && lk_hit) begin
            rsp_d_q <= lk_data;
         end else if (ld_acc) begin
            st_q        <= LIC_MISS;
            miss_addr_q <= ld_addr;
         end
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_data  = rsp_d_q;
   assign inv_ack   = ack_q;
   assign mem_req   = (st_q == LIC_MISS);
   assign mem_addr  = miss_addr_q;

endmodule

// File: rtl/lazy_inval_cache.sv
module lazy_inval_cache #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 3,
   parameter int Q_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              bar_req,
   output logic              bar_done,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              inv_ready,
   output logic              inv_ack,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_fill_valid,
   input  logic [DATA_W-1:0] mem_fill_data
);

   localparam int CNT_W = lic_pkg::lic_cnt_bits(Q_DEPTH);

   if (DATA_W < 1) begin : g_bad_data
      $error("lazy_inval_cache: DATA_W must be positive");
   end

   logic              lk_hit;
   logic [DATA_W-1:0] lk_data;
   logic [CNT_W-1:0]  q_cnt;
   logic              q_head_void, dq_push, dq_pop, dq_apply, fill_en;
   logic [ADDR_W-1:0] q_head_addr;

   lic_access_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(Q_DEPTH)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .bar_req(bar_req), .bar_done(bar_done),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_ack(inv_ack),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
      .lk_hit(lk_hit), .lk_data(lk_data),
      .q_count(q_cnt), .q_head_void(q_head_void),
      .q_push(dq_push), .q_pop(dq_pop), .apply_en(dq_apply), .fill_en(fill_en)
   );

   lic_inval_queue #(
      .ADDR_W(ADDR_W), .DEPTH(Q_DEPTH)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(dq_push), .push_addr(inv_addr),
      .pop(dq_pop),
      .void_en(fill_en), .void_addr(mem_addr),
      .head_addr(q_head_addr), .head_void(q_head_void),
      .count(q_cnt)
   );

   lic_line_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(ld_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .wr_en(fill_en), .wr_addr(mem_addr), .wr_data(mem_fill_data),
      .clr_en(dq_apply), .clr_addr(q_head_addr)
   );

endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
   parameter int ADDR_W  = 12,
   parameter int Q_DEPTH = 8,
   localparam int CNT_W  = lic_pkg::lic_cnt_bits(Q_DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              ld_ready,
   input logic              rsp_valid,
   input logic              bar_done,
   input logic              inv_valid,
   input logic              inv_ready,
   input logic              inv_ack,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_fill_valid,
   input logic [CNT_W-1:0]  q_cnt,
   input logic              dq_pop
);

   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_quiet_in_reset: assert (!inv_ack && !mem_req && !rsp_valid && !bar_done);
      end
   end

   a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_ready) |=> inv_ack);

   a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(inv_valid && inv_ready) |=> !inv_ack);

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CNT_W'(Q_DEPTH));

   a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == CNT_W'(Q_DEPTH)) |-> (!inv_ready && !ld_ready));

   a_r4_drain_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      dq_pop |-> (!(ld_valid && ld_ready) && !(mem_req && mem_fill_valid)));

   a_r6_done_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      bar_done |-> (q_cnt == '0 && !mem_req));

   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_fill_valid) |=> (mem_req && $stable(mem_addr)));

   a_r7_rsp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_fill_valid) |=> (rsp_valid && !mem_req));

   a_r10_one_miss: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ld_ready);

endmodule

bind lazy_inval_cache lic_checker #(
   .ADDR_W(ADDR_W), .Q_DEPTH(Q_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ld_valid(ld_valid), .ld_ready(ld_ready), .rsp_valid(rsp_valid),
   .bar_done(bar_done), .inv_valid(inv_valid), .inv_ready(inv_ready),
   .inv_ack(inv_ack), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_fill_valid(mem_fill_valid), .q_cnt(q_cnt), .dq_pop(dq_pop)
);

// File: tb/sim_lazy_inval_cache.sv
module sim_lazy_inval_cache;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int IW = 3;
   localparam int QD = 8;
   localparam int NL = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0, bar_req = 1'b0, inv_valid = 1'b0;
   logic [AW-1:0] ld_addr = '0, inv_addr = '0;
   logic          mem_fill_valid = 1'b0;
   logic [DW-1:0] mem_fill_data = '0;
   logic          ld_ready, rsp_valid, bar_done, inv_ready, inv_ack, mem_req;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] mem_addr;

   always #5 clk = ~clk;

   lazy_inval_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .Q_DEPTH(QD)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .bar_req(bar_req), .bar_done(bar_done),
      .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready), .inv_ack(inv_ack),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct { logic [AW-1:0] a; bit dead; } pend_t;
   pend_t         mq[$];
   bit            m_vld [NL];
   logic [AW-1:0] m_addr [NL];
   logic [DW-1:0] m_dat [NL];
   bit            m_miss = 0;
   logic [AW-1:0] m_maddr = '0;
   bit            e_rsp_v = 0, e_ack = 0;
   logic [DW-1:0] e_rsp_d = '0;

   function automatic bit m_ld_ready();
      return !m_miss && (mq.size() < QD) && !bar_req;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         for (int i = 0; i < NL; i++) m_vld[i] = 0;
         m_miss = 0; e_rsp_v = 0; e_ack = 0;
      end else begin
         int  ix;
         bit  acc, hit, fill, push, pop;
         ix   = int'(ld_addr) % NL;
         acc  = ld_valid && m_ld_ready();
         hit  = m_vld[ix] && m_addr[ix] == ld_addr;
         fill = m_miss && mem_fill_valid;
         push = inv_valid && (mq.size() < QD);
         pop  = (mq.size() > 0) && !acc && !fill;
         e_ack   = push;
         e_rsp_v = fill || (acc && hit);
         if (fill) e_rsp_d = mem_fill_data;
         else if (acc && hit) e_rsp_d = m_dat[ix];
         if (pop) begin
            pend_t p;
            int    px;
            p  = mq.pop_front();
            px = int'(p.a) % NL;
            if (!p.dead && m_vld[px] && m_addr[px] == p.a) m_vld[px] = 0;
         end
         if (fill) begin
            int fx;
            fx = int'(m_maddr) % NL;
            m_vld[fx] = 1; m_addr[fx] = m_maddr; m_dat[fx] = mem_fill_data;
            foreach (mq[k]) if (mq[k].a == m_maddr) mq[k].dead = 1;
            m_miss = 0;
         end
         if (acc && !hit) begin
            m_miss = 1; m_maddr = ld_addr;
         end
         if (push) mq.push_back('{a: inv_addr, dead: 0});
      end
   end

   task automatic cmp_all();
      bit full;
      full = mq.size() >= QD;
      chk(ld_ready === m_ld_ready(), "R10", "ld_ready", ld_ready, m_ld_ready());
      chk(inv_ready === !full, "R3", "inv_ready", inv_ready, !full);
      chk(inv_ack === e_ack, "R2", "inv_ack", inv_ack, e_ack);
      chk(mem_req === m_miss, "R7", "mem_req", mem_req, m_miss);
      if (m_miss) chk(mem_addr === m_maddr, "R7", "mem_addr", mem_addr, m_maddr);
      chk(rsp_valid === e_rsp_v, "R8", "rsp_valid", rsp_valid, e_rsp_v);
      if (e_rsp_v) chk(rsp_data === e_rsp_d, "R8", "rsp_data", rsp_data, e_rsp_d);
      chk(bar_done === (bar_req && mq.size() == 0 && !m_miss), "R6", "bar_done",
          bar_done, (bar_req && mq.size() == 0 && !m_miss));
   endtask

   // ---------------- memory responder and stimulus ----------------
   int  ver [32];
   int  lat_cfg = 3, lat_left = 3;
   bit  rand_lat = 0;

   function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
      return {ver[a[4:0]][15:0], 4'h0, a};
   endfunction

   task automatic step(input bit lv, input logic [AW-1:0] la,
                       input bit iv, input logic [AW-1:0] ia, input bit br);
      @(negedge clk);
      ld_valid = lv; ld_addr = la; inv_valid = iv; inv_addr = ia; bar_req = br;
      mem_fill_valid = 1'b0;
      if (mem_req) begin
         if (lat_left == 0) begin
            mem_fill_valid = 1'b1;
            mem_fill_data  = memval(mem_addr);
            lat_left = rand_lat ? $urandom_range(0, 4) : lat_cfg;
         end else lat_left--;
      end
      #1;
      if (iv && inv_ready) ver[ia[4:0]]++;
      cmp_all();
   endtask

   task automatic load_wait(input logic [AW-1:0] a, output logic [DW-1:0] d, output bit missed);
      int guard;
      missed = 0; d = '0; guard = 0;
      do begin
         step(1, a, 0, 0, 0);
         guard++;
      end while (!ld_ready && guard < 50);
      guard = 0;
      do begin
         step(0, 0, 0, 0, 0);
         if (mem_req) begin
            missed = 1;
            chk(ld_ready === 1'b0, "R10", "ld_ready during miss", ld_ready, 0);
         end
         guard++;
      end while (!rsp_valid && guard < 50);
      d = rsp_data;
   endtask

   task automatic barrier();
      int guard;
      guard = 0;
      do begin
         step(0, 0, 0, 0, 1);
         guard++;
      end while (!bar_done && guard < 60);
      chk(bar_done === 1'b1, "R6", "barrier completes", bar_done, 1);
      step(0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++; n_chk++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, old5;
      bit            missed;
      bit            bar_on;
      foreach (ver[i]) ver[i] = 0;

      // R1: reset state
      repeat (3) step(0, 0, 0, 0, 0);
      chk(!inv_ack && !mem_req && !rsp_valid && !bar_done, "R1", "outputs in reset",
          {inv_ack, mem_req, rsp_valid, bar_done}, 0);
      @(negedge clk); rst_n = 1'b1;
      load_wait(5, d, missed);
      chk(missed, "R1", "first load misses", missed, 1);
      chk(d === memval(5), "R7", "fill data returned", d, memval(5));
      old5 = d;

      // R8 stale hit with queued invalidation, R2 immediate ack
      step(1, 5, 1, 5, 0);
      step(1, 5, 0, 0, 0);
      chk(inv_ack === 1'b1, "R2", "ack one cycle after accept", inv_ack, 1);
      step(0, 0, 0, 0, 0);
      chk(rsp_valid && rsp_data === old5, "R8", "stale hit data", rsp_data, old5);

      // R6 barrier then R5 applied invalidation forces a miss
      barrier();
      load_wait(5, d, missed);
      chk(missed, "R5", "line invalidated after barrier", missed, 1);
      chk(d === memval(5), "R7", "new data after refetch", d, memval(5));

      // R5 tag mismatch leaves line valid
      load_wait(1, d, missed);
      step(0, 0, 1, 9, 0);
      barrier();
      load_wait(1, d, missed);
      chk(!missed, "R5", "mismatched tag keeps line", missed, 0);

      // R3 full queue back-pressure, R4 drain starved by loads
      load_wait(0, d, missed);
      for (int k = 0; k < QD; k++) step(1, 0, 1, AW'(16 + k), 0);
      step(1, 0, 1, 30, 0);
      chk(inv_ready === 1'b0, "R3", "inv_ready low when full", inv_ready, 0);
      chk(ld_ready === 1'b0, "R3", "ld_ready low when full", ld_ready, 0);
      step(0, 0, 0, 0, 0);
      chk(inv_ready === 1'b1, "R4", "slot freed by idle drain", inv_ready, 1);
      barrier();

      // R9 fill voids a queued invalidation of the same line
      load_wait(2, d, missed);
      lat_cfg = 3; lat_left = 3;
      for (int k = 0; k < 6; k++) step(1, 2, 1, AW'(17 + k), 0);
      step(1, 2, 1, 12, 0);
      load_wait(12, d, missed);
      chk(missed && d === memval(12), "R9", "miss fill data", d, memval(12));
      barrier();
      load_wait(12, d, missed);
      chk(!missed, "R9", "voided entry kept fresh line", missed, 0);
      chk(d === memval(12), "R9", "fresh data kept", d, memval(12));

      // mixed traffic against the model
      rand_lat = 1; bar_on = 0;
      for (int c = 0; c < 4000; c++) begin
         if (bar_on && bar_done) bar_on = 0;
         else if (!bar_on && $urandom_range(0, 40) == 0) bar_on = 1;
         step($urandom_range(0, 9) < 6, AW'($urandom_range(0, 31)),
              $urandom_range(0, 9) < 4, AW'($urandom_range(0, 31)), bar_on);
      end
      barrier();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule